// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block resolves one conditional relative branch per request for a small 8-bit processor core. For each request it decides whether the branch is taken. It then produces the program counter the core should fetch from next. The decision comes either from the current negative, zero, overflow and carry flags, or from a masked test of a data byte against a mask byte.

The core presents several inputs together with a request strobe. These are the address of the branch opcode, a branch kind, a condition code, the signed displacement byte, the flags, and, for bit tests, the tested byte, the mask and the total instruction length. One clock later the resolver returns a result strobe, a taken flag and the next program counter.

When the branch is taken, the target is measured from the first byte after the displacement, which is the last byte of the instruction. When it is not taken, the next program counter is simply the first byte after the instruction. All address arithmetic wraps around the address space.

Top module: `bru_unit`

## Requirements
- R1: A request sampled with `req_valid`=1 on a rising edge drives `res_valid`=1 with `res_taken` and `res_next_pc` for that request after that same edge. A cycle without a request drives `res_valid`=0 and leaves `res_taken` and `res_next_pc` unchanged.
- R2: A taken branch gives `res_next_pc` = opcode address + instruction length + displacement, where the displacement is the 8-bit two's-complement `disp` sign-extended (range -128 to +127). The length is 2 for kinds 0 and 3, and `instr_len` for kinds 1 and 2.
- R3: A branch that is not taken gives `res_next_pc` = opcode address + instruction length, with the length defined as in R2.
- R4: With kind 0, condition code 0 (always) is taken for any flags, and code 1 (never) is never taken. Code 0 with displacement 0xFE resolves to the opcode address itself.
- R5: Unsigned conditions with kind 0: code 2 (higher) is taken when C=0 and Z=0. Code 3 (lower or same) is taken when C=1 or Z=1. Code 4 (higher or same) is taken when C=0. Code 5 (lower) is taken when C=1.
- R6: Single-flag conditions with kind 0: code 6 is taken when Z=0 and code 7 when Z=1. Code 8 is taken when V=0 and code 9 when V=1. Code 10 is taken when N=0 and code 11 when N=1.
- R7: Signed conditions with kind 0: code 12 (greater or equal) is taken when N xor V = 0. Code 13 (less) is taken when N xor V = 1. Code 14 (greater) is taken when Z=0 and N xor V = 0. Code 15 (less or equal) is taken when Z=1 or N xor V = 1.
- R8: Kind 1 (bit-set branch) is taken when every bit that is 1 in `test_mask` is also 1 in `test_byte`. Kind 2 (bit-clear branch) is taken when every such bit is 0 in `test_byte`. An all-zero mask makes both kinds taken.
- R9: For kinds 1 and 2, `cond_sel` and the four flags have no effect on the result. For kinds 0 and 3, `test_byte`, `test_mask` and `instr_len` have no effect on the result.
- R10: Kind 3 resolves exactly as kind 0.
- R11: Target and fall-through addresses are computed modulo 2^16, so they wrap past 0xFFFF and below 0x0000.
- R12: While `rst` is high on a rising edge, `res_valid`, `res_taken` and `res_next_pc` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| op_addr | input | 16 | Address of the branch opcode |
| br_kind | input | 2 | 0 flag branch, 1 bit-set branch, 2 bit-clear branch, 3 same as 0 |
| cond_sel | input | 4 | Flag condition code (R4 to R7) |
| disp | input | 8 | Signed displacement byte |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| test_byte | input | 8 | Byte tested by bit branches |
| test_mask | input | 8 | Bit-select mask for bit branches |
| instr_len | input | 3 | Instruction length for bit branches |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 16 | Next program counter |

## Verification
The bench builds the resolver with its default widths: a 16-bit address, an 8-bit data byte and a 3-bit length field. With these widths, the wrap past 0xFFFF and the full -128 to +127 displacement range can be driven directly. The signed and unsigned conditions are checked against real comparisons of operand pairs whose flags the bench derives from a subtraction. Every mask bit position and the empty mask can also be exercised in the bit-test branches.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int unsigned COND_W = 4;
    localparam int unsigned KIND_W = 2;
    localparam int unsigned REL_LEN = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_FLAG = 2'd0,
        KIND_BSET = 2'd1,
        KIND_BCLR = 2'd2,
        KIND_ALT  = 2'd3
    } br_kind_e;

    typedef enum logic [COND_W-1:0] {
        C_ALWAYS = 4'd0,
        C_NEVER  = 4'd1,
        C_HI     = 4'd2,
        C_LS     = 4'd3,
        C_CCLR   = 4'd4,
        C_CSET   = 4'd5,
        C_ZCLR   = 4'd6,
        C_ZSET   = 4'd7,
        C_VCLR   = 4'd8,
        C_VSET   = 4'd9,
        C_NCLR   = 4'd10,
        C_NSET   = 4'd11,
        C_SGE    = 4'd12,
        C_SLT    = 4'd13,
        C_SGT    = 4'd14,
        C_SLE    = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Conditions come in complementary pairs; the low code bit inverts
    // the sense of the pair's base test.
    function automatic logic pair_base(input logic [COND_W-2:0] grp,
                                       input flags_t f);
        logic lt;
        lt = f.n ^ f.v;
        case (grp)
            3'd0:    pair_base = 1'b1;
            3'd1:    pair_base = ~f.c & ~f.z;
            3'd2:    pair_base = ~f.c;
            3'd3:    pair_base = ~f.z;
            3'd4:    pair_base = ~f.v;
            3'd5:    pair_base = ~f.n;
            3'd6:    pair_base = ~lt;
            default: pair_base = ~f.z & ~lt;
        endcase
    endfunction

    function automatic logic is_bit_kind(input br_kind_e k);
        is_bit_kind = (k == KIND_BSET) || (k == KIND_BCLR);
    endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [COND_W-1:0] cond_sel,
    input  flags_t            flags,
    output logic              cond_true
);

    logic base;

    always_comb begin
        base      = pair_base(cond_sel[COND_W-1:1], flags);
        cond_true = base ^ cond_sel[0];
    end

endmodule

// File: rtl/bru_mask_test.sv
module bru_mask_test #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] test_byte,
    input  logic [DATA_W-1:0] test_mask,
    output logic              all_ones,
    output logic              all_zeros
);

    logic [DATA_W-1:0] ok_one;
    logic [DATA_W-1:0] ok_zero;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            // An unselected bit never blocks either test.
            assign ok_one[i]  = ~test_mask[i] |  test_byte[i];
            assign ok_zero[i] = ~test_mask[i] | ~test_byte[i];
        end
    endgenerate

    assign all_ones  = &ok_one;
    assign all_zeros = &ok_zero;

endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN_W  = 3
) (
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] disp,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    localparam int unsigned EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] tgt_pc;

    always_comb begin
        seq_pc   = op_addr + ADDR_W'(ins_len);
        disp_ext = {{EXT_W{disp[DATA_W-1]}}, disp};
        tgt_pc   = seq_pc + disp_ext;
        next_pc  = taken ? tgt_pc : seq_pc;
    end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
    import bru_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [1:0]        br_kind,
    input  logic [3:0]        cond_sel,
    input  logic [DATA_W-1:0] disp,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic [DATA_W-1:0] test_byte,
    input  logic [DATA_W-1:0] test_mask,
    input  logic [LEN_W-1:0]  instr_len,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_next_pc
);

    br_kind_e          kind;
    flags_t            flags;
    logic              cond_true;
    logic              bits_one;
    logic              bits_zero;
    logic              taken_d;
    logic [LEN_W-1:0]  len_d;
    logic [ADDR_W-1:0] pc_d;

    assign kind  = br_kind_e'(br_kind);
    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bru_cond_eval u_cond (
        .cond_sel  (cond_sel),
        .flags     (flags),
        .cond_true (cond_true)
    );

    bru_mask_test #(.DATA_W(DATA_W)) u_mask (
        .test_byte (test_byte),
        .test_mask (test_mask),
        .all_ones  (bits_one),
        .all_zeros (bits_zero)
    );

    always_comb begin
        case (kind)
            KIND_BSET: taken_d = bits_one;
            KIND_BCLR: taken_d = bits_zero;
            default:   taken_d = cond_true;
        endcase
        len_d = is_bit_kind(kind) ? instr_len : LEN_W'(REL_LEN);
    end

    bru_target_calc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_tgt (
        .op_addr (op_addr),
        .disp    (disp),
        .ins_len (len_d),
        .taken   (taken_d),
        .next_pc (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken   <= taken_d;
                res_next_pc <= pc_d;
            end
        end
    end

    // R1: result strobe follows the request one edge later
    p_valid_latency_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(req_valid)));

    // R1: idle cycles leave the result untouched
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(res_taken) && $stable(res_next_pc)));

    // R4: always and never codes
    p_always_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_bit_kind(kind) && cond_sel == C_ALWAYS) |=> res_taken);

    p_never_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_bit_kind(kind) && cond_sel == C_NEVER) |=> !res_taken);

    // R3: a flag branch that falls through lands two bytes on
    p_fallthru_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_bit_kind(kind)) |=>
        (res_taken || res_next_pc == ADDR_W'($past(op_addr) + ADDR_W'(REL_LEN))));

    // R8: mask tests
    p_bset_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == KIND_BSET && ((test_byte & test_mask) == test_mask))
        |=> res_taken);

    p_bclr_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == KIND_BCLR && ((test_byte & test_mask) != '0))
        |=> !res_taken);

endmodule

// File: tb/sim_bru_unit.sv
module sim_bru_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] op_addr = '0;
    logic [1:0]  br_kind = '0;
    logic [3:0]  cond_sel = '0;
    logic [7:0]  disp = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic [7:0]  test_byte = '0;
    logic [7:0]  test_mask = '0;
    logic [2:0]  instr_len = 3'd3;
    logic        res_valid;
    logic        res_taken;
    logic [15:0] res_next_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bru_unit u0 (
        .clk (clk), .rst (rst), .req_valid (req_valid), .op_addr (op_addr),
        .br_kind (br_kind), .cond_sel (cond_sel), .disp (disp),
        .flag_n (flag_n), .flag_z (flag_z), .flag_v (flag_v), .flag_c (flag_c),
        .test_byte (test_byte), .test_mask (test_mask), .instr_len (instr_len),
        .res_valid (res_valid), .res_taken (res_taken), .res_next_pc (res_next_pc)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request, sampled at the next falling edge.
    task automatic issue(input logic [15:0] a, input logic [1:0] k, input logic [3:0] c,
                         input logic [7:0] d, input logic [3:0] nzvc,
                         input logic [7:0] tb, input logic [7:0] tm, input logic [2:0] ln);
        @(negedge clk);
        op_addr = a; br_kind = k; cond_sel = c; disp = d;
        {flag_n, flag_z, flag_v, flag_c} = nzvc;
        test_byte = tb; test_mask = tm; instr_len = ln;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [15:0] pc_of(input logic [15:0] a, input int len,
                                          input logic [7:0] d, input bit tk);
        int s;
        s = tk ? (int'(a) + len + int'($signed(d))) : (int'(a) + len);
        return 16'(s);
    endfunction

    task automatic expect_res(input string tag, input bit tk, input logic [15:0] pc);
        check({tag, " valid"}, {15'd0, res_valid}, 16'd1);
        check({tag, " taken"}, {15'd0, res_taken}, {15'd0, tk});
        check({tag, " pc"}, res_next_pc, pc);
    endtask

    task automatic t_reset_r12();
        check("R12 reset valid", {15'd0, res_valid}, 16'd0);
        check("R12 reset taken", {15'd0, res_taken}, 16'd0);
        check("R12 reset pc", res_next_pc, 16'd0);
    endtask

    task automatic t_latency_r1();
        issue(16'h4000, 2'd0, 4'd0, 8'h20, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R1 issue", 1'b1, 16'h4022);
        @(negedge clk);
        check("R1 idle valid", {15'd0, res_valid}, 16'd0);
        check("R1 idle hold taken", {15'd0, res_taken}, 16'd1);
        check("R1 idle hold pc", res_next_pc, 16'h4022);
    endtask

    task automatic t_always_never_r4();
        issue(16'h1234, 2'd0, 4'd0, 8'hFE, 4'hF, 8'h00, 8'h00, 3'd3);
        expect_res("R4 self loop", 1'b1, 16'h1234);
        issue(16'h1234, 2'd0, 4'd1, 8'h40, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R4 never R3 fallthru", 1'b0, 16'h1236);
        issue(16'h1234, 2'd0, 4'd1, 8'h40, 4'hF, 8'h00, 8'h00, 3'd3);
        expect_res("R4 never flags set", 1'b0, 16'h1236);
    endtask

    task automatic t_disp_r2();
        issue(16'h8000, 2'd0, 4'd0, 8'h7F, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R2 max forward", 1'b1, 16'h8081);
        issue(16'h8000, 2'd0, 4'd0, 8'h80, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R2 max backward", 1'b1, 16'h7F82);
    endtask

    // Flags come from a - b; expected outcomes from true comparisons.
    task automatic t_compare_r5_r7(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] df;
        logic [3:0] nzvc;
        bit         ex [16];
        df = {1'b0, a} - {1'b0, b};
        nzvc = {df[7], df[7:0] == 8'd0, (a[7] != b[7]) && (df[7] != a[7]), df[8]};
        ex[2]  = a > b;   ex[3]  = a <= b;  ex[4] = a >= b;  ex[5] = a < b;
        ex[12] = $signed(a) >= $signed(b);  ex[13] = $signed(a) <  $signed(b);
        ex[14] = $signed(a) >  $signed(b);  ex[15] = $signed(a) <= $signed(b);
        for (int c = 2; c < 16; c++) begin
            if (c >= 6 && c <= 11) continue;
            issue(16'h2000 + 16'(c), 2'd0, 4'(c), 8'h10, nzvc, 8'h00, 8'h00, 3'd3);
            expect_res($sformatf("%s cmp %h-%h code %0d", (c < 6) ? "R5" : "R7", a, b, c),
                       ex[c], pc_of(16'h2000 + 16'(c), 2, 8'h10, ex[c]));
        end
    endtask

    task automatic t_flags_r6();
        for (int f = 0; f < 16; f++) begin
            logic [3:0] nzvc;
            bit         ex [6];
            nzvc = 4'(f);
            ex[0] = !nzvc[2]; ex[1] = nzvc[2];
            ex[2] = !nzvc[1]; ex[3] = nzvc[1];
            ex[4] = !nzvc[3]; ex[5] = nzvc[3];
            for (int c = 6; c < 12; c++) begin
                issue(16'h3000, 2'd0, 4'(c), 8'hF0, nzvc, 8'h00, 8'h00, 3'd3);
                check($sformatf("R6 flags %h code %0d", nzvc, c),
                      {15'd0, res_taken}, {15'd0, ex[c-6]});
            end
        end
    endtask

    task automatic t_bits_r8();
        issue(16'h5000, 2'd1, 4'd1, 8'h08, 4'h0, 8'hF3, 8'h03, 3'd4);
        expect_res("R8 bset all set", 1'b1, 16'h500C);
        issue(16'h5000, 2'd1, 4'd0, 8'h08, 4'h0, 8'hF3, 8'h07, 3'd4);
        expect_res("R8 bset one clear", 1'b0, 16'h5004);
        issue(16'h5000, 2'd2, 4'd1, 8'hF8, 4'h0, 8'h0C, 8'hF3, 3'd3);
        expect_res("R8 bclr all clear", 1'b1, 16'h4FFB);
        issue(16'h5000, 2'd2, 4'd0, 8'hF8, 4'h0, 8'h8C, 8'hF3, 3'd3);
        expect_res("R8 bclr msb set", 1'b0, 16'h5003);
        issue(16'h5000, 2'd1, 4'd1, 8'h01, 4'h0, 8'h00, 8'h00, 3'd4);
        expect_res("R8 bset empty mask", 1'b1, 16'h5005);
        issue(16'h5000, 2'd2, 4'd1, 8'h01, 4'h0, 8'hFF, 8'h00, 3'd4);
        expect_res("R8 bclr empty mask", 1'b1, 16'h5005);
        for (int i = 0; i < 8; i++) begin
            issue(16'h6000, 2'd1, 4'd0, 8'h02, 4'h0, ~(8'h01 << i), 8'h01 << i, 3'd4);
            check($sformatf("R8 bset bit %0d clear", i), {15'd0, res_taken}, 16'd0);
        end
    endtask

    task automatic t_ignore_r9();
        issue(16'h7000, 2'd1, 4'd1, 8'h10, 4'hF, 8'hFF, 8'hFF, 3'd5);
        expect_res("R9 bit kind ignores never code", 1'b1, 16'h7015);
        issue(16'h7000, 2'd2, 4'd0, 8'h10, 4'h5, 8'h01, 8'h01, 3'd5);
        expect_res("R9 bit kind ignores always code", 1'b0, 16'h7005);
        issue(16'h7000, 2'd0, 4'd1, 8'h10, 4'h0, 8'hFF, 8'h00, 3'd6);
        expect_res("R9 flag kind ignores mask and len", 1'b0, 16'h7002);
        issue(16'h7000, 2'd0, 4'd7, 8'h10, 4'h4, 8'h00, 8'hFF, 3'd0);
        expect_res("R9 flag kind ignores byte", 1'b1, 16'h7012);
    endtask

    task automatic t_alt_kind_r10();
        issue(16'h0900, 2'd3, 4'd2, 8'h04, 4'h0, 8'h00, 8'hFF, 3'd5);
        expect_res("R10 kind3 hi taken", 1'b1, 16'h0906);
        issue(16'h0900, 2'd3, 4'd2, 8'h04, 4'h1, 8'hFF, 8'hFF, 3'd5);
        expect_res("R10 kind3 hi not taken", 1'b0, 16'h0902);
    endtask

    task automatic t_wrap_r11();
        issue(16'hFFFF, 2'd0, 4'd0, 8'h10, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R11 wrap up", 1'b1, 16'h0011);
        issue(16'h0001, 2'd0, 4'd0, 8'h80, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R11 wrap down", 1'b1, 16'hFF83);
        issue(16'hFFFE, 2'd0, 4'd1, 8'h10, 4'h0, 8'h00, 8'h00, 3'd3);
        expect_res("R11 R3 fallthru wrap", 1'b0, 16'h0000);
    endtask

    task automatic t_midrun_reset_r12();
        issue(16'hABCD, 2'd0, 4'd0, 8'h01, 4'h0, 8'h00, 8'h00, 3'd3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset_r12();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r12();
        rst = 1'b0;
        t_latency_r1();
        t_always_never_r4();
        t_disp_r2();
        t_compare_r5_r7(8'h10, 8'h20);
        t_compare_r5_r7(8'h80, 8'h7F);
        t_compare_r5_r7(8'h05, 8'h05);
        t_compare_r5_r7(8'hFF, 8'h01);
        t_flags_r6();
        t_bits_r8();
        t_ignore_r9();
        t_alt_kind_r10();
        t_wrap_r11();
        t_midrun_reset_r12();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule